// File: doc/BRIEF.md
# Temperature-Indexed Setpoint Selector

This block turns a signed die or case temperature reading into three control setpoints by table lookup. Each strobe of a valid temperature selects one of 36 windows, each four degrees wide. The first window starts at -40 degrees. The selected entry is read from each of three independent tables: one for the optical power-control loop and one for each of two DAC channels. The three chosen bytes are registered onto the outputs. There is no interpolation: the setpoint steps from one entry to the next at each window edge.

Software loads the tables through a byte write port. A two-bit page field picks the table. Each table occupies byte offsets 0x80 through 0xA3 of its page, so entry k sits at offset 0x80 + k. The outputs change only when a new temperature is strobed. A table write therefore never disturbs a setpoint that is already being driven. The new value appears at the next temperature update.

Top module: `temp_lut_sel`

## Requirements
- R1: After reset the three setpoints and out_vld are 0, and every table entry reads back as 0 on the first strobe.
- R2: For a temperature T in units of 1/256 degree with -10240 <= T < 25600, the selected entry is floor((T + 10240) / 1024). So 0 degrees selects entry 10, and each step of 1024 counts moves one entry.
- R3: Any T below -10240 (colder than -40 degrees) selects entry 0.
- R4: Any T at or above 25600 (+100 degrees and warmer) selects entry 35.
- R5: The tables are independent. wr_page 0 loads the power setpoint table (setpt_pwr), 1 the first DAC table (setpt_dac1) and 2 the second DAC table (setpt_dac2). All three outputs come from the same entry index.
- R6: A write with wr_en high stores wr_data into entry wr_addr - 0x80 for wr_addr in 0x80..0xA3. Writes to other addresses, or with wr_page 3, change no table.
- R7: When temp_vld is high at a rising clock edge, the outputs take the selected entries at that edge. out_vld is high for exactly the following cycle.
- R8: Without temp_vld the setpoints hold their values, even while table entries are being written.
- R9: A write that lands in the same cycle as a temp_vld to the entry being selected does not affect that update. The setpoint shows the old entry, and the new value appears at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| temp_vld | input | 1 | Strobe: temp_in holds a new reading |
| temp_in | input | 16 | Signed temperature, 1/256 degree per count |
| wr_en | input | 1 | Table byte write enable |
| wr_page | input | 2 | Table select: 0 power, 1 DAC1, 2 DAC2, 3 none |
| wr_addr | input | 8 | Byte offset within the page; 0x80..0xA3 are entries |
| wr_data | input | 8 | Byte to store |
| setpt_pwr | output | 8 | Power-control setpoint |
| setpt_dac1 | output | 8 | First DAC setpoint |
| setpt_dac2 | output | 8 | Second DAC setpoint |
| out_vld | output | 1 | One-cycle pulse after each temperature update |

## Verification
The bench targets the window edges: exactly -40 degrees, one count below and one count under the next 4-degree boundary. It also covers 99.996 and 100 degrees and both extremes of the 16-bit range. An off-by-one bias, a lost sign extension or a missing clamp would show up there as a neighbouring or wrapped entry. Writes just outside 0x80..0xA3 and to page 3 are followed by strobes on the neighbouring entries. An address decode that is too wide would alter entry 0, entry 35 or entry 5 there. Holding the setpoints across writes, and a write that coincides with a strobe, expose a design that reads the tables combinationally or forwards fresh write data.

// File: rtl/temp_lut_pkg.sv
package temp_lut_pkg;

  // Number of parallel tables and width of the page select.
  localparam int N_TBL     = 3;
  localparam int TBL_SEL_W = 2;

  // Page codes on the write port; also the output slot of each table.
  typedef enum logic [TBL_SEL_W-1:0] {
    TBL_PWR  = 2'd0,
    TBL_DAC1 = 2'd1,
    TBL_DAC2 = 2'd2,
    TBL_RSVD = 2'd3
  } tbl_id_e;

endpackage

// File: rtl/temp_rst_sync.sv
module temp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/temp_idx_calc.sv
module temp_idx_calc #(
  parameter int TEMP_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int MIN_DEG  = -40,
  parameter int STEP_DEG = 4,
  parameter int N_ENT    = 36,
  parameter int IDX_W    = $clog2(N_ENT)
) (
  input  logic signed [TEMP_W-1:0] temp,
  output logic        [IDX_W-1:0]  idx
);

  // Two guard bits keep the biased sum from overflowing.
  localparam int SUM_W   = TEMP_W + 2;
  localparam int STEP_SH = FRAC_W + $clog2(STEP_DEG);
  localparam logic signed [SUM_W-1:0] BIAS =
    SUM_W'((-MIN_DEG) * (1 << FRAC_W));
  localparam logic signed [SUM_W-1:0] HI_LIM =
    SUM_W'((N_ENT - 1) * STEP_DEG * (1 << FRAC_W));

  logic signed [SUM_W-1:0] sum;
  logic        [SUM_W-1:0] quo;

  always_comb begin
    sum = {{2{temp[TEMP_W-1]}}, temp} + BIAS;
    quo = sum >> STEP_SH;
    if (sum < 0) begin
      idx = '0;
    end else if (sum >= HI_LIM) begin
      idx = IDX_W'(N_ENT - 1);
    end else begin
      idx = quo[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/temp_lut_bank.sv
module temp_lut_bank #(
  parameter int N_ENT  = 36,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int BASE   = 128,
  parameter int IDX_W  = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] setpt
);

  logic [DATA_W-1:0] mem_q [N_ENT];
  logic [DATA_W-1:0] mem_d [N_ENT];
  logic [DATA_W-1:0] setpt_q;
  logic [DATA_W-1:0] setpt_d;
  logic [ADDR_W-1:0] off;
  logic              in_rng;
  logic              wr_ce;
  logic [IDX_W-1:0]  ent;

  // Address decode: only the entry window of the page is writable.
  always_comb begin
    off    = wr_addr - ADDR_W'(BASE);
    in_rng = (wr_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(N_ENT));
    wr_ce  = wr_hit && in_rng;
    ent    = off[IDX_W-1:0];
  end

  // Next-state for the table storage.
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (wr_ce) begin
      mem_d[ent] = wr_data;
    end
  end

  // Output reads the stored (pre-write) entry, so a same-cycle write waits.
  always_comb begin
    setpt_d = setpt_q;
    if (upd) begin
      setpt_d = mem_q[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        mem_q[i] <= '0;
      end
    end else if (wr_ce) begin
      for (int i = 0; i < N_ENT; i++) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setpt_q <= '0;
    end else if (upd) begin
      setpt_q <= setpt_d;
    end
  end

  assign setpt = setpt_q;

endmodule

// File: rtl/temp_lut_sel.sv
module temp_lut_sel
  import temp_lut_pkg::*;
#(
  parameter int TEMP_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int N_ENT    = 36,
  parameter int STEP_DEG = 4,
  parameter int MIN_DEG  = -40,
  parameter int TBL_BASE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_vld,
  input  logic signed [TEMP_W-1:0] temp_in,
  input  logic                     wr_en,
  input  logic [TBL_SEL_W-1:0]     wr_page,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        setpt_pwr,
  output logic [DATA_W-1:0]        setpt_dac1,
  output logic [DATA_W-1:0]        setpt_dac2,
  output logic                     out_vld
);

  localparam int IDX_W = $clog2(N_ENT);

  logic              rst_sync_n;
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] setpt_all [N_TBL];
  logic              vld_q;
  logic              vld_d;

  temp_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  temp_idx_calc #(
    .TEMP_W  (TEMP_W),
    .FRAC_W  (FRAC_W),
    .MIN_DEG (MIN_DEG),
    .STEP_DEG(STEP_DEG),
    .N_ENT   (N_ENT),
    .IDX_W   (IDX_W)
  ) u_idx (
    .temp(temp_in),
    .idx (cur_idx)
  );

  for (genvar g = 0; g < N_TBL; g++) begin : g_bank
    logic hit;
    assign hit = wr_en && (wr_page == TBL_SEL_W'(g));
    temp_lut_bank #(
      .N_ENT (N_ENT),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .BASE  (TBL_BASE),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_hit (hit),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .upd    (temp_vld),
      .rd_idx (cur_idx),
      .setpt  (setpt_all[g])
    );
  end

  always_comb begin
    vld_d = temp_vld;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign out_vld    = vld_q;
  assign setpt_pwr  = setpt_all[TBL_PWR];
  assign setpt_dac1 = setpt_all[TBL_DAC1];
  assign setpt_dac2 = setpt_all[TBL_DAC2];

endmodule

// File: rtl/temp_lut_sel_chk.sv
module temp_lut_sel_chk #(
  parameter int TEMP_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int N_ENT    = 36,
  parameter int STEP_DEG = 4,
  parameter int MIN_DEG  = -40,
  parameter int TBL_BASE = 128
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     temp_vld,
  input logic signed [TEMP_W-1:0] temp_in,
  input logic                     wr_en,
  input logic [1:0]               wr_page,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [DATA_W-1:0]        setpt_pwr,
  input logic [DATA_W-1:0]        setpt_dac1,
  input logic [DATA_W-1:0]        setpt_dac2,
  input logic                     out_vld
);

  localparam int LO_T = MIN_DEG * (1 << FRAC_W);
  localparam int HI_T = LO_T + (N_ENT - 1) * STEP_DEG * (1 << FRAC_W);

  // Shadows of the first and last power-table entries, tracked from the port.
  logic [DATA_W-1:0] sh_lo;
  logic [DATA_W-1:0] sh_hi;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sh_lo <= '0;
      sh_hi <= '0;
    end else if (wr_en && wr_page == 2'd0) begin
      if (wr_addr == ADDR_W'(TBL_BASE)) sh_lo <= wr_data;
      if (wr_addr == ADDR_W'(TBL_BASE + N_ENT - 1)) sh_hi <= wr_data;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (setpt_pwr == '0 && setpt_dac1 == '0 &&
                     setpt_dac2 == '0 && !out_vld));

  assert_clamp_low_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (temp_vld && int'(temp_in) < LO_T) |=> (setpt_pwr == $past(sh_lo)));

  assert_clamp_high_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (temp_vld && int'(temp_in) >= HI_T) |=> (setpt_pwr == $past(sh_hi)));

  assert_pulse_on_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    temp_vld |=> out_vld);

  assert_pulse_off_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !temp_vld |=> !out_vld);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !temp_vld |=> ($stable(setpt_pwr) && $stable(setpt_dac1) && $stable(setpt_dac2)));

endmodule

bind temp_lut_sel temp_lut_sel_chk #(
  .TEMP_W  (TEMP_W),
  .FRAC_W  (FRAC_W),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .N_ENT   (N_ENT),
  .STEP_DEG(STEP_DEG),
  .MIN_DEG (MIN_DEG),
  .TBL_BASE(TBL_BASE)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .temp_vld  (temp_vld),
  .temp_in   (temp_in),
  .wr_en     (wr_en),
  .wr_page   (wr_page),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .setpt_pwr (setpt_pwr),
  .setpt_dac1(setpt_dac1),
  .setpt_dac2(setpt_dac2),
  .out_vld   (out_vld)
);

// File: tb/temp_lut_sel_tb.sv
module temp_lut_sel_tb;

  logic        clk;
  logic        rst_n;
  logic        temp_vld;
  logic signed [15:0] temp_in;
  logic        wr_en;
  logic [1:0]  wr_page;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  setpt_pwr;
  logic [7:0]  setpt_dac1;
  logic [7:0]  setpt_dac2;
  logic        out_vld;

  int n_chk;
  int n_bad;
  bit done;
  int model [3][36];

  temp_lut_sel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .temp_vld  (temp_vld),
    .temp_in   (temp_in),
    .wr_en     (wr_en),
    .wr_page   (wr_page),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .setpt_pwr (setpt_pwr),
    .setpt_dac1(setpt_dac1),
    .setpt_dac2(setpt_dac2),
    .out_vld   (out_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_idx(int t);
    if (t < -10240) return 0;
    if (t >= 25600) return 35;
    return (t + 10240) / 1024;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(int page, int addr, int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_page = 2'(page);
    wr_addr = 8'(addr);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (page < 3 && addr >= 'h80 && addr <= 'hA3) model[page][addr - 'h80] = data;
  endtask

  task automatic check_outs(string req, int k);
    check({req, " pwr"},  int'(setpt_pwr),  model[0][k]);
    check({req, " dac1"}, int'(setpt_dac1), model[1][k]);
    check({req, " dac2"}, int'(setpt_dac2), model[2][k]);
  endtask

  // One strobe; outputs are sampled at the falling edge after the update.
  task automatic do_strobe(string req, int t);
    @(negedge clk);
    temp_in  = 16'(t);
    temp_vld = 1'b1;
    @(negedge clk);
    temp_vld = 1'b0;
    check_outs(req, exp_idx(t));
    check("R7 pulse high", int'(out_vld), 1);
    @(negedge clk);
    check("R7 pulse low", int'(out_vld), 0);
  endtask

  task automatic t_reset;
    check("R1 pwr", int'(setpt_pwr), 0);
    check("R1 dac1", int'(setpt_dac1), 0);
    check("R1 dac2", int'(setpt_dac2), 0);
    check("R1 vld", int'(out_vld), 0);
    do_strobe("R1 empty table", 0);
  endtask

  task automatic t_fill;
    for (int k = 0; k < 36; k++) begin
      do_write(0, 'h80 + k, k * 3 + 1);
      do_write(1, 'h80 + k, 'h80 + k);
      do_write(2, 'h80 + k, 'hFF - k * 2);
    end
    do_strobe("R5 tables at 0C", 0);
  endtask

  task automatic t_windows;
    do_strobe("R2 at -40C", -10240);
    do_strobe("R2 below first edge", -10240 + 1023);
    do_strobe("R2 first edge", -10240 + 1024);
    do_strobe("R2 mid", 5000);
    do_strobe("R2 last inner", 25599);
    do_strobe("R2 negative mid", -1);
  endtask

  task automatic t_clamp;
    do_strobe("R3 one below -40C", -10241);
    do_strobe("R3 minimum", -32768);
    do_strobe("R4 at 100C", 25600);
    do_strobe("R4 maximum", 32767);
  endtask

  task automatic t_ignored;
    do_write(0, 'h7F, 'hAA);
    do_write(0, 'hA4, 'hBB);
    do_write(3, 'h85, 'hCC);
    do_write(1, 'h00, 'hDD);
    do_strobe("R6 entry 0 untouched", -10240);
    do_strobe("R6 entry 35 untouched", 30000);
    do_strobe("R6 entry 5 untouched", -5120);
  endtask

  task automatic t_hold;
    int old;
    do_strobe("R8 setup", 0);
    old = model[1][10];
    do_write(1, 'h80 + 10, 'h5A);
    repeat (3) @(negedge clk);
    check("R8 dac1 held", int'(setpt_dac1), old);
    check("R8 pwr held", int'(setpt_pwr), model[0][10]);
    do_strobe("R8 new value after strobe", 0);
  endtask

  task automatic t_same_cycle;
    int old;
    old = model[2][20];
    @(negedge clk);
    temp_in  = 16'(20 * 1024 - 10240);
    temp_vld = 1'b1;
    wr_en    = 1'b1;
    wr_page  = 2'd2;
    wr_addr  = 8'('h80 + 20);
    wr_data  = 8'h33;
    @(negedge clk);
    temp_vld = 1'b0;
    wr_en    = 1'b0;
    check("R9 old value shown", int'(setpt_dac2), old);
    model[2][20] = 'h33;
    do_strobe("R9 new value next strobe", 20 * 1024 - 10240);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    temp_vld = 1'b0;
    temp_in  = '0;
    wr_en    = 1'b0;
    wr_page  = '0;
    wr_addr  = '0;
    wr_data  = '0;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 36; k++) model[p][k] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_windows();
    t_clamp();
    t_ignored();
    t_hold();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule